// File: doc/BRIEF.md
# TDM Frame Timing Calculator

This block turns a serial audio frame description into the numbers a two-channel
frame serializer needs. Software or a sequencer presents a framing style, a slot
layout (count, width and a receive and a transmit slot mask) or, instead, a plain
bits-per-frame ratio, together with the sample data length. It then pulses `start`.
A few cycles later the block pulses `done` and presents the frame length, the sync
pulse length and polarity, the data delay and the bit offsets of both channels in
each direction. It also presents an error code that says whether the request can be
serialized.

With paired framing styles (I2S and the two justified styles) the slot numbers in
the masks are logical. Even logical slots fill the first half of the frame and odd
logical slots fill the second half, so the block interleaves them before it turns
slots into bit offsets. DSP styles use the slot numbers as they are. The results
stay on the outputs until the next accepted request.

Top module: `tdm_frame_calc`

## Requirements
- R1: `fmt_mode` is encoded as 0 = I2S, 1 = left-justified, 2 = right-justified, 3 = DSP-A and 4 = DSP-B. The data delay is 1 for I2S and DSP-A, 0 for left-justified and DSP-B, and slot width minus data length for right-justified.
- R2: The effective layout is chosen as follows. When `tdm_en`=1 and `slot_cnt`≠0, the slot fields are used and the frame is slot_cnt×slot_wid. Otherwise, when `frame_ratio`≠0, the layout is 2 slots of width frame_ratio/2 (rounded down), both masks are 0b11 and the frame is frame_ratio. Otherwise it is 2 slots each `data_len` wide, both masks 0b11, and a frame of 2×data_len.
- R3: In TDM layout each mask is first cut to its low `slot_cnt` bits. If either cut mask does not have exactly two bits set, the error code is 1.
- R4: Channel 1 of a direction uses the lowest set mask bit and channel 2 the highest. A channel's bit offset is physical slot × slot width + data delay.
- R5: For modes 0–2 an even logical slot s maps to physical slot s/2 and an odd one to (s>>1) + slot_count/2. For modes 3–4 the physical slot equals the logical slot.
- R6: Error code 2 is reported for an odd slot count in modes 0–2, for an odd frame length in mode 2, and for any mode code from 5 to 7.
- R7: Error code 3 is reported for any of these: frame length above 1024, `frame_ratio` above 1024 when it is the source, slot width 0, data length above slot width, or a slot count above MAX_SLOTS (16).
- R8: The sync length is frame/2 (rounded down) in modes 0–2 and 1 in modes 3–4. `sync_pol` is 1 for I2S and 0 otherwise, XORed with `fs_invert`.
- R9: Mask errors (1) take precedence over length errors (3), which take precedence over parity and mode errors (2). With any error, every timing output is 0.
- R10: `done` is a one-cycle pulse in the third cycle after an accepted `start`. A `start` that arrives while an earlier request is in flight is ignored.
- R11: All outputs are 0 after reset. Between `done` pulses they keep their values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| tdm_en | input | 1 | Use the slot count, width and mask fields |
| fmt_mode | input | 3 | Framing style code (R1) |
| slot_cnt | input | 5 | Number of slots in TDM layout |
| slot_wid | input | 11 | Slot width in bit clocks |
| data_len | input | 6 | Sample data length in bits |
| rx_mask | input | 16 | Receive logical slot mask |
| tx_mask | input | 16 | Transmit logical slot mask |
| frame_ratio | input | 11 | Bit clocks per frame when no TDM layout is given; 0 = none |
| fs_invert | input | 1 | Invert the frame sync polarity |
| done | output | 1 | Result valid pulse |
| err_code | output | 2 | 0 ok, 1 mask, 2 parity/mode, 3 length |
| frame_len | output | 11 | Frame length in bit clocks |
| sync_len | output | 11 | Sync pulse length in bit clocks |
| sync_pol | output | 1 | Frame-start sync edge: 1 = falling |
| data_delay | output | 11 | Bit clocks from slot start to data MSB |
| rx_pos1 | output | 11 | Receive channel 1 bit offset |
| rx_pos2 | output | 11 | Receive channel 2 bit offset |
| tx_pos1 | output | 11 | Transmit channel 1 bit offset |
| tx_pos2 | output | 11 | Transmit channel 2 bit offset |

## Verification
The bench aims at the interleaved slot map. It uses masks whose low bit is odd and
whose high bit is even, so channel 1 lands after channel 2. A design that skipped
the half-frame offset, or that used it in DSP modes, would put the channels on the
wrong bits. It probes the exact 1024-bit frame and the 1026 ratio, an odd ratio in
right-justified mode and mask bits above the slot count. A wrong bound, a missing
mask cut or a missing parity test shows up there as a wrong or absent error code.
Requests that break several rules at once expose a wrong error priority. A second
start during a busy request, and input changes after `done`, expose results that
were overwritten or not held.

// File: rtl/tdm_calc_pkg.sv
package tdm_calc_pkg;
  typedef enum logic [2:0] {
    FMT_I2S  = 3'd0,
    FMT_LJ   = 3'd1,
    FMT_RJ   = 3'd2,
    FMT_DSPA = 3'd3,
    FMT_DSPB = 3'd4
  } fmt_e;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_MASK   = 2'd1,
    ERR_PARITY = 2'd2,
    ERR_LENGTH = 2'd3
  } err_e;
endpackage

// File: rtl/tdm_cfg_resolve.sv
module tdm_cfg_resolve #(
  parameter int MAX_SLOTS = 16,
  parameter int MAX_FRAME = 1024,
  parameter int CNT_W  = 5,
  parameter int LEN_W  = 11,
  parameter int DLEN_W = 6,
  parameter int PROD_W = CNT_W + LEN_W
) (
  input  logic                 tdm_en,
  input  logic [CNT_W-1:0]     slot_cnt,
  input  logic [LEN_W-1:0]     slot_wid,
  input  logic [DLEN_W-1:0]    data_len,
  input  logic [MAX_SLOTS-1:0] rx_mask,
  input  logic [MAX_SLOTS-1:0] tx_mask,
  input  logic [LEN_W-1:0]     frame_ratio,
  output logic [CNT_W-1:0]     eff_slots,
  output logic [LEN_W-1:0]     eff_wid,
  output logic [MAX_SLOTS-1:0] eff_rx,
  output logic [MAX_SLOTS-1:0] eff_tx,
  output logic [PROD_W-1:0]    eff_frame,
  output logic                 ratio_over
);
  logic [MAX_SLOTS-1:0] keep;

  always_comb begin
    for (int i = 0; i < MAX_SLOTS; i++) keep[i] = (CNT_W'(i) < slot_cnt);
  end

  always_comb begin
    ratio_over = 1'b0;
    if (tdm_en && slot_cnt != '0) begin
      eff_slots = slot_cnt;
      eff_wid   = slot_wid;
      eff_rx    = rx_mask & keep;
      eff_tx    = tx_mask & keep;
      eff_frame = PROD_W'(slot_cnt) * PROD_W'(slot_wid);
    end else if (frame_ratio != '0) begin
      eff_slots  = CNT_W'(2);
      eff_wid    = frame_ratio >> 1;
      eff_rx     = MAX_SLOTS'(3);
      eff_tx     = MAX_SLOTS'(3);
      eff_frame  = PROD_W'(frame_ratio);
      ratio_over = (frame_ratio > LEN_W'(MAX_FRAME));
    end else begin
      eff_slots = CNT_W'(2);
      eff_wid   = LEN_W'(data_len);
      eff_rx    = MAX_SLOTS'(3);
      eff_tx    = MAX_SLOTS'(3);
      eff_frame = PROD_W'({data_len, 1'b0});
    end
  end
endmodule

// File: rtl/tdm_mask_scan.sv
module tdm_mask_scan #(
  parameter int MAX_SLOTS = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input  logic [MAX_SLOTS-1:0] mask,
  output logic [IDX_W-1:0]     lo_idx,
  output logic [IDX_W-1:0]     hi_idx,
  output logic                 two_set
);
  logic [CNT_W-1:0] ones;

  always_comb begin
    ones   = '0;
    lo_idx = '0;
    hi_idx = '0;
    for (int i = MAX_SLOTS - 1; i >= 0; i--) begin
      if (mask[i]) lo_idx = IDX_W'(i);
    end
    for (int i = 0; i < MAX_SLOTS; i++) begin
      if (mask[i]) begin
        hi_idx = IDX_W'(i);
        ones   = ones + CNT_W'(1);
      end
    end
    two_set = (ones == CNT_W'(2));
  end
endmodule

// File: rtl/tdm_slot_place.sv
module tdm_slot_place #(
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 5,
  parameter int LEN_W  = 11,
  parameter int PROD_W = CNT_W + LEN_W
) (
  input  logic [IDX_W-1:0] lslot,
  input  logic             interleave,
  input  logic [CNT_W-1:0] half_slots,
  input  logic [LEN_W-1:0] wid,
  input  logic [LEN_W-1:0] delay,
  output logic [LEN_W-1:0] pos
);
  logic [CNT_W-1:0] phys;

  always_comb begin
    if (!interleave)   phys = CNT_W'(lslot);
    else if (lslot[0]) phys = CNT_W'(lslot >> 1) + half_slots;
    else               phys = CNT_W'(lslot >> 1);
    pos = LEN_W'(PROD_W'(phys) * PROD_W'(wid) + PROD_W'(delay));
  end
endmodule

// File: rtl/tdm_frame_calc.sv
module tdm_frame_calc
  import tdm_calc_pkg::*;
#(
  parameter int MAX_SLOTS = 16,
  parameter int MAX_FRAME = 1024,
  parameter int MAX_DATA  = 32,
  parameter int CNT_W  = $clog2(MAX_SLOTS + 1),
  parameter int LEN_W  = $clog2(MAX_FRAME + 1),
  parameter int DLEN_W = $clog2(MAX_DATA + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 tdm_en,
  input  logic [2:0]           fmt_mode,
  input  logic [CNT_W-1:0]     slot_cnt,
  input  logic [LEN_W-1:0]     slot_wid,
  input  logic [DLEN_W-1:0]    data_len,
  input  logic [MAX_SLOTS-1:0] rx_mask,
  input  logic [MAX_SLOTS-1:0] tx_mask,
  input  logic [LEN_W-1:0]     frame_ratio,
  input  logic                 fs_invert,
  output logic                 done,
  output logic [1:0]           err_code,
  output logic [LEN_W-1:0]     frame_len,
  output logic [LEN_W-1:0]     sync_len,
  output logic                 sync_pol,
  output logic [LEN_W-1:0]     data_delay,
  output logic [LEN_W-1:0]     rx_pos1,
  output logic [LEN_W-1:0]     rx_pos2,
  output logic [LEN_W-1:0]     tx_pos1,
  output logic [LEN_W-1:0]     tx_pos2
);
  localparam int IDX_W  = $clog2(MAX_SLOTS);
  localparam int PROD_W = CNT_W + LEN_W;
  localparam int NPOS   = 4;

  // ---- stage A: effective layout ----
  logic [CNT_W-1:0]     r_slots;
  logic [LEN_W-1:0]     r_wid;
  logic [MAX_SLOTS-1:0] r_rx, r_tx;
  logic [PROD_W-1:0]    r_frame;
  logic                 r_over;

  tdm_cfg_resolve #(
    .MAX_SLOTS(MAX_SLOTS), .MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W),
    .LEN_W(LEN_W), .DLEN_W(DLEN_W), .PROD_W(PROD_W)
  ) u_resolve (
    .tdm_en(tdm_en), .slot_cnt(slot_cnt), .slot_wid(slot_wid),
    .data_len(data_len), .rx_mask(rx_mask), .tx_mask(tx_mask),
    .frame_ratio(frame_ratio), .eff_slots(r_slots), .eff_wid(r_wid),
    .eff_rx(r_rx), .eff_tx(r_tx), .eff_frame(r_frame), .ratio_over(r_over)
  );

  logic                 a_v, b_v, busy, accept;
  logic [CNT_W-1:0]     a_slots;
  logic [LEN_W-1:0]     a_wid;
  logic [MAX_SLOTS-1:0] a_mask [2];
  logic [PROD_W-1:0]    a_frame;
  logic                 a_over, a_inv;
  logic [2:0]           a_mode;
  logic [DLEN_W-1:0]    a_dlen;

  assign busy   = a_v | b_v;
  assign accept = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_v     <= 1'b0;
      a_slots <= '0;
      a_wid   <= '0;
      a_mask[0] <= '0;
      a_mask[1] <= '0;
      a_frame <= '0;
      a_over  <= 1'b0;
      a_inv   <= 1'b0;
      a_mode  <= '0;
      a_dlen  <= '0;
    end else begin
      a_v <= accept;
      if (accept) begin
        a_slots   <= r_slots;
        a_wid     <= r_wid;
        a_mask[0] <= r_rx;
        a_mask[1] <= r_tx;
        a_frame   <= r_frame;
        a_over    <= r_over;
        a_inv     <= fs_invert;
        a_mode    <= fmt_mode;
        a_dlen    <= data_len;
      end
    end
  end

  // ---- stage B: mask scan and rule checks ----
  logic [IDX_W-1:0] s_lo [2];
  logic [IDX_W-1:0] s_hi [2];
  logic             s_two [2];

  generate
    for (genvar g = 0; g < 2; g++) begin : g_scan
      tdm_mask_scan #(.MAX_SLOTS(MAX_SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_scan (
        .mask(a_mask[g]), .lo_idx(s_lo[g]), .hi_idx(s_hi[g]), .two_set(s_two[g])
      );
    end
  endgenerate

  logic             paired, mask_bad, len_bad, par_bad;
  logic [1:0]       n_err;
  logic [LEN_W-1:0] n_delay, n_sync;

  always_comb begin
    paired   = (a_mode == FMT_I2S) || (a_mode == FMT_LJ) || (a_mode == FMT_RJ);
    mask_bad = !s_two[0] || !s_two[1];
    len_bad  = a_over || (a_frame > PROD_W'(MAX_FRAME)) || (a_wid == '0) ||
               (LEN_W'(a_dlen) > a_wid) || (a_slots > CNT_W'(MAX_SLOTS));
    par_bad  = (a_mode > FMT_DSPB) || (paired && a_slots[0]) ||
               ((a_mode == FMT_RJ) && a_frame[0]);
    if (mask_bad)     n_err = ERR_MASK;
    else if (len_bad) n_err = ERR_LENGTH;
    else if (par_bad) n_err = ERR_PARITY;
    else              n_err = ERR_NONE;
    case (a_mode)
      FMT_I2S, FMT_DSPA: n_delay = LEN_W'(1);
      FMT_RJ:            n_delay = a_wid - LEN_W'(a_dlen);
      default:           n_delay = '0;
    endcase
    n_sync = paired ? LEN_W'(a_frame >> 1) : LEN_W'(1);
  end

  logic [1:0]       b_err;
  logic [LEN_W-1:0] b_delay, b_sync, b_wid, b_frame;
  logic             b_pol, b_ilv;
  logic [CNT_W-1:0] b_half;
  logic [IDX_W-1:0] b_slot [NPOS];

  always_ff @(posedge clk) begin
    if (rst) begin
      b_v     <= 1'b0;
      b_err   <= '0;
      b_delay <= '0;
      b_sync  <= '0;
      b_wid   <= '0;
      b_frame <= '0;
      b_pol   <= 1'b0;
      b_ilv   <= 1'b0;
      b_half  <= '0;
      for (int i = 0; i < NPOS; i++) b_slot[i] <= '0;
    end else begin
      b_v <= a_v;
      if (a_v) begin
        b_err     <= n_err;
        b_delay   <= n_delay;
        b_sync    <= n_sync;
        b_wid     <= a_wid;
        b_frame   <= LEN_W'(a_frame);
        b_pol     <= (a_mode == FMT_I2S) ^ a_inv;
        b_ilv     <= paired;
        b_half    <= a_slots >> 1;
        b_slot[0] <= s_lo[0];
        b_slot[1] <= s_hi[0];
        b_slot[2] <= s_lo[1];
        b_slot[3] <= s_hi[1];
      end
    end
  end

  // ---- stage C: bit offsets and output registers ----
  logic [LEN_W-1:0] c_pos [NPOS];

  generate
    for (genvar p = 0; p < NPOS; p++) begin : g_place
      tdm_slot_place #(.IDX_W(IDX_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .PROD_W(PROD_W)) u_place (
        .lslot(b_slot[p]), .interleave(b_ilv), .half_slots(b_half),
        .wid(b_wid), .delay(b_delay), .pos(c_pos[p])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      err_code   <= '0;
      frame_len  <= '0;
      sync_len   <= '0;
      sync_pol   <= 1'b0;
      data_delay <= '0;
      rx_pos1    <= '0;
      rx_pos2    <= '0;
      tx_pos1    <= '0;
      tx_pos2    <= '0;
    end else begin
      done <= b_v;
      if (b_v) begin
        err_code <= b_err;
        if (b_err != ERR_NONE) begin
          frame_len  <= '0;
          sync_len   <= '0;
          sync_pol   <= 1'b0;
          data_delay <= '0;
          rx_pos1    <= '0;
          rx_pos2    <= '0;
          tx_pos1    <= '0;
          tx_pos2    <= '0;
        end else begin
          frame_len  <= b_frame;
          sync_len   <= b_sync;
          sync_pol   <= b_pol;
          data_delay <= b_delay;
          rx_pos1    <= c_pos[0];
          rx_pos2    <= c_pos[1];
          tx_pos1    <= c_pos[2];
          tx_pos2    <= c_pos[3];
        end
      end
    end
  end
endmodule

// File: rtl/tdm_frame_calc_chk.sv
module tdm_frame_calc_chk #(
  parameter int LEN_W = 11,
  parameter int MAX_FRAME = 1024
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [1:0]       err_code,
  input logic [LEN_W-1:0] frame_len,
  input logic [LEN_W-1:0] sync_len,
  input logic [LEN_W-1:0] data_delay,
  input logic [LEN_W-1:0] rx_pos1,
  input logic [LEN_W-1:0] rx_pos2,
  input logic [LEN_W-1:0] tx_pos1,
  input logic [LEN_W-1:0] tx_pos2
);
  assert_done_latency_R10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |-> ##3 done);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_err_zeroes_R9: assert property (@(posedge clk) disable iff (rst)
    (done && err_code != 2'd0) |-> (frame_len == '0 && sync_len == '0 &&
      data_delay == '0 && rx_pos1 == '0 && rx_pos2 == '0 &&
      tx_pos1 == '0 && tx_pos2 == '0));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(err_code) && $stable(frame_len) && $stable(sync_len) &&
      $stable(data_delay) && $stable(rx_pos1) && $stable(tx_pos2)));

  assert_sync_fits_R8: assert property (@(posedge clk) disable iff (rst)
    (done && err_code == 2'd0) |-> (sync_len != '0 && sync_len <= frame_len));

  assert_frame_cap_R7: assert property (@(posedge clk) disable iff (rst)
    (done && err_code == 2'd0) |-> (frame_len != '0 && frame_len <= LEN_W'(MAX_FRAME)));
endmodule

bind tdm_frame_calc tdm_frame_calc_chk #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .err_code(err_code), .frame_len(frame_len), .sync_len(sync_len),
  .data_delay(data_delay), .rx_pos1(rx_pos1), .rx_pos2(rx_pos2),
  .tx_pos1(tx_pos1), .tx_pos2(tx_pos2)
);

// File: tb/tdm_frame_calc_tb_top.sv
`timescale 1ns/100ps
module tdm_frame_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        tdm_en = 1'b0;
  logic [2:0]  fmt_mode = '0;
  logic [4:0]  slot_cnt = '0;
  logic [10:0] slot_wid = '0;
  logic [5:0]  data_len = '0;
  logic [15:0] rx_mask = '0;
  logic [15:0] tx_mask = '0;
  logic [10:0] frame_ratio = '0;
  logic        fs_invert = 1'b0;
  logic        done;
  logic [1:0]  err_code;
  logic [10:0] frame_len, sync_len, data_delay, rx_pos1, rx_pos2, tx_pos1, tx_pos2;
  logic        sync_pol;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  tdm_frame_calc dut_i (
    .clk(clk), .rst(rst), .start(start), .tdm_en(tdm_en), .fmt_mode(fmt_mode),
    .slot_cnt(slot_cnt), .slot_wid(slot_wid), .data_len(data_len),
    .rx_mask(rx_mask), .tx_mask(tx_mask), .frame_ratio(frame_ratio),
    .fs_invert(fs_invert), .done(done), .err_code(err_code),
    .frame_len(frame_len), .sync_len(sync_len), .sync_pol(sync_pol),
    .data_delay(data_delay), .rx_pos1(rx_pos1), .rx_pos2(rx_pos2),
    .tx_pos1(tx_pos1), .tx_pos2(tx_pos2)
  );

  // expected results
  int e_err, e_frame, e_sync, e_pol, e_delay;
  int e_pos [4];

  task automatic check_eq(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int phys_of(int s, bit ilv, int half);
    if (!ilv) return s;
    return (s % 2 == 1) ? (s / 2) + half : s / 2;
  endfunction

  task automatic model(int md, bit te, int sc, int sw, int dl, int rm, int tm, int ra, bit iv);
    int slots, wid, frame, rxm, txm, half, delay, lo, hi, cnt;
    bit over, mbad, lbad, pbad, paired;
    int m [2];
    int sl [4];
    over = 0;
    if (te && sc != 0) begin
      slots = sc; wid = sw; frame = sc * sw;
      rxm = rm & ((1 << sc) - 1); txm = tm & ((1 << sc) - 1);
    end else if (ra != 0) begin
      slots = 2; wid = ra / 2; frame = ra; rxm = 3; txm = 3; over = (ra > 1024);
    end else begin
      slots = 2; wid = dl; frame = 2 * dl; rxm = 3; txm = 3;
    end
    m[0] = rxm; m[1] = txm;
    mbad = 0;
    for (int d = 0; d < 2; d++) begin
      cnt = 0; lo = -1; hi = 0;
      for (int i = 0; i < 16; i++) if (m[d][i]) begin
        cnt++; hi = i; if (lo < 0) lo = i;
      end
      if (lo < 0) lo = 0;
      if (cnt != 2) mbad = 1;
      sl[2*d] = lo; sl[2*d+1] = hi;
    end
    paired = (md <= 2);
    lbad = over || frame > 1024 || wid == 0 || dl > wid || slots > 16;
    pbad = (md > 4) || (paired && slots % 2 == 1) || (md == 2 && frame % 2 == 1);
    e_err = mbad ? 1 : lbad ? 3 : pbad ? 2 : 0;
    case (md)
      0, 3:    delay = 1;
      2:       delay = wid - dl;
      default: delay = 0;
    endcase
    half = slots / 2;
    if (e_err != 0) begin
      e_frame = 0; e_sync = 0; e_pol = 0; e_delay = 0;
      for (int p = 0; p < 4; p++) e_pos[p] = 0;
    end else begin
      e_frame = frame;
      e_sync  = paired ? frame / 2 : 1;
      e_pol   = ((md == 0) ? 1 : 0) ^ int'(iv);
      e_delay = delay;
      for (int p = 0; p < 4; p++) e_pos[p] = phys_of(sl[p], paired, half) * wid + delay;
    end
  endtask

  task automatic drive(int md, bit te, int sc, int sw, int dl, int rm, int tm, int ra, bit iv);
    fmt_mode = 3'(md); tdm_en = te; slot_cnt = 5'(sc); slot_wid = 11'(sw);
    data_len = 6'(dl); rx_mask = 16'(rm); tx_mask = 16'(tm);
    frame_ratio = 11'(ra); fs_invert = iv;
  endtask

  task automatic compare_all(string req);
    check_eq(req, "err_code", int'(err_code), e_err);
    check_eq(req, "frame_len", int'(frame_len), e_frame);
    check_eq(req, "sync_len", int'(sync_len), e_sync);
    check_eq(req, "sync_pol", int'(sync_pol), e_pol);
    check_eq(req, "data_delay", int'(data_delay), e_delay);
    check_eq(req, "rx_pos1", int'(rx_pos1), e_pos[0]);
    check_eq(req, "rx_pos2", int'(rx_pos2), e_pos[1]);
    check_eq(req, "tx_pos1", int'(tx_pos1), e_pos[2]);
    check_eq(req, "tx_pos2", int'(tx_pos2), e_pos[3]);
  endtask

  // one request: start high for one edge, done expected after the third edge
  task automatic run(string req, int md, bit te, int sc, int sw, int dl, int rm, int tm, int ra, bit iv);
    @(negedge clk);
    drive(md, te, sc, sw, dl, rm, tm, ra, iv);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check_eq("R10", "done early", int'(done), 0);
    @(negedge clk);
    check_eq("R10", "done", int'(done), 1);
    model(md, te, sc, sw, dl, rm, tm, ra, iv);
    compare_all(req);
    @(negedge clk);
    check_eq("R10", "done pulse width", int'(done), 0);
  endtask

  task automatic t_reset;
    check_eq("R11", "reset done", int'(done), 0);
    check_eq("R11", "reset err", int'(err_code), 0);
    check_eq("R11", "reset frame", int'(frame_len), 0);
    check_eq("R11", "reset rx_pos2", int'(rx_pos2), 0);
    check_eq("R11", "reset pol", int'(sync_pol), 0);
  endtask

  task automatic t_default_i2s;
    run("R2", 0, 0, 0, 0, 16, 0, 0, 0, 0);
    check_eq("R1", "i2s delay literal", int'(data_delay), 1);
    check_eq("R2", "default frame literal", int'(frame_len), 32);
    check_eq("R8", "i2s sync literal", int'(sync_len), 16);
    check_eq("R4", "rx_pos2 literal", int'(rx_pos2), 17);
    check_eq("R8", "i2s pol literal", int'(sync_pol), 1);
  endtask

  task automatic t_ratio_lj;
    run("R2", 1, 0, 0, 0, 24, 0, 0, 64, 0);
    check_eq("R2", "ratio ch2 literal", int'(tx_pos2), 32);
    run("R2", 1, 1, 0, 40, 24, 0, 0, 64, 0); // tdm_en with zero slot count falls back to ratio
  endtask

  task automatic t_tdm_rj;
    run("R5", 2, 1, 8, 32, 24, 16'h0006, 16'h0081, 0, 0);
    check_eq("R5", "rj rx_pos1 literal", int'(rx_pos1), 136);
    check_eq("R4", "rj rx_pos2 literal", int'(rx_pos2), 40);
    check_eq("R1", "rj delay literal", int'(data_delay), 8);
  endtask

  task automatic t_dsp;
    run("R5", 3, 1, 5, 16, 16, 16'h0012, 16'h0005, 0, 0);
    check_eq("R5", "dspa rx_pos2 literal", int'(rx_pos2), 65);
    run("R1", 4, 1, 4, 32, 20, 16'h000C, 16'h0003, 0, 0);
    check_eq("R1", "dspb rx_pos1 literal", int'(rx_pos1), 64);
  endtask

  task automatic t_masks;
    run("R3", 3, 1, 4, 16, 16, 16'h0103, 16'h0009, 0, 0);
    run("R3", 3, 1, 4, 16, 16, 16'h0003, 16'h0101, 0, 0);
    check_eq("R3", "cut mask err literal", int'(err_code), 1);
    run("R3", 4, 1, 8, 16, 16, 16'h0007, 16'h0003, 0, 0);
  endtask

  task automatic t_parity;
    run("R6", 0, 1, 3, 16, 16, 16'h0003, 16'h0003, 0, 0);
    run("R6", 1, 1, 5, 16, 16, 16'h0011, 16'h0003, 0, 0);
    run("R6", 2, 0, 0, 0, 16, 0, 0, 49, 0);
    check_eq("R6", "rj odd frame literal", int'(err_code), 2);
    run("R6", 6, 0, 0, 0, 16, 0, 0, 0, 0);
  endtask

  task automatic t_length;
    run("R7", 4, 1, 16, 65, 16, 16'h0003, 16'h0003, 0, 0);
    run("R7", 1, 0, 0, 0, 16, 0, 0, 1026, 0);
    run("R7", 3, 1, 2, 16, 24, 16'h0003, 16'h0003, 0, 0);
    run("R7", 3, 1, 2, 0, 0, 16'h0003, 16'h0003, 0, 0);
    run("R7", 4, 1, 20, 8, 8, 16'h0003, 16'h0003, 0, 0);
    run("R7", 4, 1, 16, 64, 32, 16'h8001, 16'h0003, 0, 0);
    check_eq("R7", "1024 frame ok", int'(err_code), 0);
    check_eq("R7", "1024 frame rx_pos2", int'(rx_pos2), 960);
    run("R7", 1, 0, 0, 0, 32, 0, 0, 1024, 0);
  endtask

  task automatic t_priority;
    run("R9", 0, 1, 16, 65, 16, 16'h0001, 16'h0003, 0, 0);
    run("R9", 0, 1, 15, 70, 16, 16'h0003, 16'h0003, 0, 0);
    check_eq("R9", "length over parity", int'(err_code), 3);
  endtask

  task automatic t_invert;
    run("R8", 0, 0, 0, 0, 32, 0, 0, 0, 1);
    run("R8", 3, 1, 2, 16, 16, 16'h0003, 16'h0003, 0, 1);
    run("R8", 2, 1, 4, 24, 16, 16'h0005, 16'h000A, 0, 0);
  endtask

  task automatic t_busy;
    @(negedge clk);
    drive(1, 1, 4, 16, 16, 16'h0003, 16'h0006, 0, 0);
    start = 1'b1;
    @(negedge clk);
    drive(4, 1, 2, 32, 16, 16'h0003, 16'h0003, 0, 0);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check_eq("R10", "busy first done", int'(done), 1);
    model(1, 1, 4, 16, 16, 16'h0003, 16'h0006, 0, 0);
    compare_all("R10");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_eq("R10", "ignored start done", int'(done), 0);
    end
  endtask

  task automatic t_hold;
    run("R11", 3, 1, 8, 16, 16, 16'h0041, 16'h0082, 0, 0);
    drive(0, 0, 0, 0, 8, 0, 0, 300, 1);
    for (int k = 0; k < 5; k++) @(negedge clk);
    compare_all("R11");
    check_eq("R11", "hold done", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_default_i2s();
    t_ratio_lj();
    t_tdm_rj();
    t_dsp();
    t_masks();
    t_parity();
    t_length();
    t_priority();
    t_invert();
    t_busy();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule